// File: doc/BRIEF.md
# 8-bit accumulator ALU with flag register

This block is the arithmetic and logic datapath of a small 8-bit processor. On a strobe it takes an operation code, the accumulator value, one operand byte and an incoming carry. It computes the new result, a write-back byte and six condition flags. The flags are sign, zero, half-carry, parity/overflow, subtract and carry. All of these land in output registers on the same clock edge. The surrounding core handles instruction decode, the register file, memory access and timing.

The operation set covers:
- add and subtract, each with and without the incoming carry;
- compare;
- AND, XOR and OR;
- increment and decrement of the operand;
- accumulator complement;
- rotate-left-circular of the accumulator;
- the nibble exchange between the accumulator and a memory byte used by the rotate-right-decimal instruction.

Each operation has its own flag rule. Any flag an operation does not define keeps the value held in the flag register.

Top module: `alu8_unit`

## Requirements
- R1: Reset (rst_n low) clears result_q, mem_q and flags_q. flags_q bit order is S=5, Z=4, H=3, P/V=2, N=1, C=0.
- R2: While strobe is low, result_q, mem_q and flags_q hold their values whatever the other inputs do. A strobed operation is visible on the outputs after the next rising clock edge.
- R3: Op 0 adds operand to acc and op 1 also adds carry_in; 0x22+0x66 with carry_in=1 gives 0x89. C is the carry out of bit 7, H the carry out of bit 3, P/V the signed overflow, N=0, and S/Z follow the result.
- R4: Op 2 subtracts operand from acc and op 3 also subtracts carry_in; 0x40−0x3F with carry_in=1 gives 0x00 with Z=1. C and H are the borrows out of bits 7 and 3, P/V the signed overflow, and N=1.
- R5: Op 4 (compare) sets flags exactly as op 2 would, but result_q returns acc unchanged.
- R6: Op 5 gives acc AND operand, with H=1, N=0 and C=0. P/V is 1 when the result has an even number of ones.
- R7: Op 6 (XOR) and op 7 (OR) clear H, N and C. S, Z and P/V (even parity) follow the result.
- R8: Op 8 returns operand+1 with N=0 and op 9 returns operand−1 with N=1. H is the carry or borrow out of bit 3. P/V is set only for operand 0x7F (op 8) or 0x80 (op 9). C keeps its previous value.
- R9: Op 10 returns the bitwise complement of acc and sets H and N. S, Z, P/V and C are kept.
- R10: Op 11 rotates acc left by one, so old bit 7 appears in result bit 0 and in C. It clears H and N and keeps S, Z and P/V.
- R11: Op 12 returns {acc[7:4], operand[3:0]} as result and {acc[3:0], operand[7:4]} as mem_q. It clears H and N, takes S and Z from the result and sets P/V to its even parity, and keeps C. For every other op, mem_q takes the operand unchanged.
- R12: Op codes 13 to 15 return acc as result and keep all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | Latch a new operation this cycle |
| op | input | 4 | Operation code |
| acc | input | 8 | Accumulator operand |
| opnd | input | 8 | Second operand or memory byte |
| carry_in | input | 1 | Carry used by the with-carry add and subtract |
| result_q | output | 8 | Registered result byte |
| mem_q | output | 8 | Registered write-back byte |
| flags_q | output | 6 | Registered flags {S,Z,H,P/V,N,C} |

## Verification
The only internal state is the flag register, which also supplies every kept flag. A corrupted flag therefore shows on flags_q in the cycle after it is latched. It also comes back later through the kept bits of INC, DEC, CPL, RLCA, RRD and the unused codes. The bench chains operations so that a stale or wrongly kept carry or sign bit is seen one strobe later. Half-carry and overflow errors appear at once, on the boundary values 0x0F/0x10, 0x7F and 0x80.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DW = 8;
    localparam int OPW = 4;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_CMP  = 4'd4,
        OP_AND  = 4'd5,
        OP_XOR  = 4'd6,
        OP_OR   = 4'd7,
        OP_INC  = 4'd8,
        OP_DEC  = 4'd9,
        OP_CPL  = 4'd10,
        OP_RLC  = 4'd11,
        OP_NIB  = 4'd12
    } op_e;

    typedef struct packed {
        logic s;
        logic z;
        logic h;
        logic pv;
        logic n;
        logic c;
    } flags_t;

    typedef struct packed {
        logic [DW-1:0] res;
        logic [DW-1:0] mem;
        flags_t        flg;
    } alu_state_t;

    function automatic logic even_par(input logic [DW-1:0] x);
        return ~^x;
    endfunction
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         hout,
    output logic         vout
);
    localparam int HW = W / 2;

    logic [W-1:0]  bx;
    logic          cx;
    logic [W:0]    full;
    logic [HW:0]   low;

    always_comb begin
        bx   = sub ? ~b : b;
        cx   = cin ^ sub;
        full = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, cx};
        low  = {1'b0, a[HW-1:0]} + {1'b0, bx[HW-1:0]} + {{HW{1'b0}}, cx};
        sum  = full[W-1:0];
        cout = full[W] ^ sub;
        hout = low[HW] ^ sub;
        vout = (a[W-1] == bx[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] and_r,
    output logic [W-1:0] xor_r,
    output logic [W-1:0] or_r,
    output logic [W-1:0] cpl_r,
    output logic [W-1:0] rot_r,
    output logic [W-1:0] nib_a,
    output logic [W-1:0] nib_m
);
    localparam int HW = W / 2;

    always_comb begin
        and_r = a & b;
        xor_r = a ^ b;
        or_r  = a | b;
        cpl_r = ~a;
        rot_r = {a[W-2:0], a[W-1]};
        nib_a = {a[W-1:HW], b[HW-1:0]};
        nib_m = {a[HW-1:0], b[W-1:HW]};
    end
endmodule

// File: rtl/alu8_unit.sv
module alu8_unit
    import alu8_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           strobe,
    input  logic [OPW-1:0] op,
    input  logic [DW-1:0]  acc,
    input  logic [DW-1:0]  opnd,
    input  logic           carry_in,
    output logic [DW-1:0]  result_q,
    output logic [DW-1:0]  mem_q,
    output logic [5:0]     flags_q
);
    alu_state_t st_d, st_q;

    logic [DW-1:0] as_a, as_b, as_sum;
    logic          as_cin, as_sub, as_c, as_h, as_v;
    logic          is_step;
    logic [DW-1:0] and_r, xor_r, or_r, cpl_r, rot_r, nib_a, nib_m;

    always_comb begin
        is_step = (op == OP_INC) || (op == OP_DEC);
        as_a    = is_step ? opnd : acc;
        as_b    = is_step ? DW'(1) : opnd;
        as_sub  = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP) || (op == OP_DEC);
        as_cin  = ((op == OP_ADC) || (op == OP_SBC)) ? carry_in : 1'b0;
    end

    alu8_addsub #(.W(DW)) i_addsub (
        .a    (as_a),
        .b    (as_b),
        .cin  (as_cin),
        .sub  (as_sub),
        .sum  (as_sum),
        .cout (as_c),
        .hout (as_h),
        .vout (as_v)
    );

    alu8_logic #(.W(DW)) i_logic (
        .a     (acc),
        .b     (opnd),
        .and_r (and_r),
        .xor_r (xor_r),
        .or_r  (or_r),
        .cpl_r (cpl_r),
        .rot_r (rot_r),
        .nib_a (nib_a),
        .nib_m (nib_m)
    );

    always_comb begin
        st_d = st_q;
        if (strobe) begin
            st_d.res = acc;
            st_d.mem = opnd;
            case (op)
                OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP: begin
                    st_d.res    = (op == OP_CMP) ? acc : as_sum;
                    st_d.flg.s  = as_sum[DW-1];
                    st_d.flg.z  = (as_sum == '0);
                    st_d.flg.h  = as_h;
                    st_d.flg.pv = as_v;
                    st_d.flg.n  = as_sub;
                    st_d.flg.c  = as_c;
                end
                OP_INC, OP_DEC: begin
                    st_d.res    = as_sum;
                    st_d.flg.s  = as_sum[DW-1];
                    st_d.flg.z  = (as_sum == '0);
                    st_d.flg.h  = as_h;
                    st_d.flg.pv = as_v;
                    st_d.flg.n  = as_sub;
                end
                OP_AND, OP_XOR, OP_OR: begin
                    st_d.res    = (op == OP_AND) ? and_r : ((op == OP_XOR) ? xor_r : or_r);
                    st_d.flg.s  = st_d.res[DW-1];
                    st_d.flg.z  = (st_d.res == '0);
                    st_d.flg.h  = (op == OP_AND);
                    st_d.flg.pv = even_par(st_d.res);
                    st_d.flg.n  = 1'b0;
                    st_d.flg.c  = 1'b0;
                end
                OP_CPL: begin
                    st_d.res   = cpl_r;
                    st_d.flg.h = 1'b1;
                    st_d.flg.n = 1'b1;
                end
                OP_RLC: begin
                    st_d.res   = rot_r;
                    st_d.flg.c = acc[DW-1];
                    st_d.flg.h = 1'b0;
                    st_d.flg.n = 1'b0;
                end
                OP_NIB: begin
                    st_d.res    = nib_a;
                    st_d.mem    = nib_m;
                    st_d.flg.s  = nib_a[DW-1];
                    st_d.flg.z  = (nib_a == '0);
                    st_d.flg.h  = 1'b0;
                    st_d.flg.n  = 1'b0;
                    st_d.flg.pv = even_par(nib_a);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result_q = st_q.res;
    assign mem_q    = st_q.mem;
    assign flags_q  = st_q.flg;
endmodule

// File: rtl/alu8_unit_chk.sv
module alu8_unit_chk
    import alu8_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           strobe,
    input logic [OPW-1:0] op,
    input logic [DW-1:0]  acc,
    input logic [DW-1:0]  result_q,
    input logic [DW-1:0]  mem_q,
    input logic [5:0]     flags_q
);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(result_q) && $stable(mem_q) && $stable(flags_q));

    p_zero_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe && (op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_AND, OP_XOR, OP_OR})
        |=> flags_q[4] == (result_q == '0));

    p_cmp_keeps_acc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe && op == OP_CMP |=> result_q == $past(acc) && flags_q[1]);

    p_and_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        strobe && op == OP_AND |=> flags_q[3] && !flags_q[1] && !flags_q[0]);

    p_step_keeps_c_r8: assert property (@(posedge clk) disable iff (!rst_n)
        strobe && (op == OP_INC || op == OP_DEC) |=> flags_q[0] == $past(flags_q[0]));

    p_cpl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        strobe && op == OP_CPL |=> result_q == ~$past(acc) && flags_q[3] && flags_q[1]);

    p_rot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        strobe && op == OP_RLC |=> result_q[0] == flags_q[0] && flags_q[0] == $past(acc[DW-1]));
endmodule

bind alu8_unit alu8_unit_chk i_chk (.*);

// File: tb/test_alu8_unit.sv
module test_alu8_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strobe = 1'b0;
    logic [3:0] op = '0;
    logic [7:0] acc = '0;
    logic [7:0] opnd = '0;
    logic       carry_in = 1'b0;
    logic [7:0] result_q, mem_q;
    logic [5:0] flags_q;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    bit sent = 0;

    typedef struct {
        logic [7:0] r;
        logic [7:0] m;
        logic [5:0] f;
        string      tag;
    } item_t;
    item_t sb[$];

    logic [5:0] mflags = '0;
    logic [7:0] last_r = '0, last_m = '0;

    always #10 clk = ~clk;

    alu8_unit i_alu8_unit (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .op(op), .acc(acc),
        .opnd(opnd), .carry_in(carry_in), .result_q(result_q),
        .mem_q(mem_q), .flags_q(flags_q)
    );

    function automatic int sgn(input logic [7:0] x);
        return (int'(x) > 127) ? int'(x) - 256 : int'(x);
    endfunction

    function automatic void model(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                                  input logic ci, input logic [5:0] fin,
                                  output logic [7:0] r, output logic [7:0] m, output logic [5:0] f);
        int ai, bi, cc, t, v;
        logic s, z, h, pv, n, c;
        {s, z, h, pv, n, c} = fin;
        ai = int'(a); bi = int'(b);
        r = a; m = b;
        cc = ((o == 1 || o == 3) && ci) ? 1 : 0;
        case (o)
            0, 1: begin
                t = ai + bi + cc; r = t[7:0]; c = (t > 255);
                h = ((ai & 15) + (bi & 15) + cc) > 15;
                v = sgn(a) + sgn(b) + cc; pv = (v > 127) || (v < -128);
                n = 0; s = r[7]; z = (r == 0);
            end
            2, 3, 4: begin
                t = ai - bi - cc; c = (t < 0);
                h = ((ai & 15) - (bi & 15) - cc) < 0;
                v = sgn(a) - sgn(b) - cc; pv = (v > 127) || (v < -128);
                n = 1; s = t[7]; z = (t[7:0] == 0);
                r = (o == 4) ? a : t[7:0];
            end
            5, 6, 7: begin
                r = (o == 5) ? (a & b) : ((o == 6) ? (a ^ b) : (a | b));
                h = (o == 5); n = 0; c = 0; s = r[7]; z = (r == 0);
                pv = ($countones(r) % 2) == 0;
            end
            8: begin
                t = bi + 1; r = t[7:0]; h = ((bi & 15) == 15); pv = (b == 8'h7F);
                n = 0; s = r[7]; z = (r == 0);
            end
            9: begin
                t = bi - 1; r = t[7:0]; h = ((bi & 15) == 0); pv = (b == 8'h80);
                n = 1; s = r[7]; z = (r == 0);
            end
            10: begin r = ~a; h = 1; n = 1; end
            11: begin r = {a[6:0], a[7]}; c = a[7]; h = 0; n = 0; end
            12: begin
                r = {a[7:4], b[3:0]}; m = {a[3:0], b[7:4]};
                s = r[7]; z = (r == 0); h = 0; n = 0;
                pv = ($countones(r) % 2) == 0;
            end
            default: ;
        endcase
        f = {s, z, h, pv, n, c};
    endfunction

    task automatic check(input string tag, input logic [7:0] r, input logic [7:0] m, input logic [5:0] f);
        n_chk++;
        if (result_q !== r || mem_q !== m || flags_q !== f) begin
            n_err++;
            $display("FAIL %s: got r=%02h m=%02h f=%06b, expected r=%02h m=%02h f=%06b",
                     tag, result_q, mem_q, flags_q, r, m, f);
        end
    endtask

    // driver: push expected item, strobe one cycle
    task automatic run_op(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                          input logic ci, input string tag);
        item_t it;
        @(negedge clk);
        op = o; acc = a; opnd = b; carry_in = ci; strobe = 1'b1;
        model(o, a, b, ci, mflags, it.r, it.m, it.f);
        it.tag = tag;
        mflags = it.f; last_r = it.r; last_m = it.m;
        sb.push_back(it);
        @(negedge clk);
        strobe = 1'b0;
    endtask

    always @(posedge clk) sent <= strobe;

    // monitor: compare one cycle after each strobe
    initial begin
        forever begin
            @(negedge clk);
            if (sent) begin
                if (sb.size() == 0) begin
                    n_chk++; n_err++;
                    $display("FAIL R2: output update without expected item, got r=%02h expected none", result_q);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check(it.tag, it.r, it.m, it.f);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", 8'h00, 8'h00, 6'b000000);
        rst_n = 1'b1;

        run_op(0, 8'h22, 8'h33, 1'b1, "R3 add ignores carry");
        run_op(0, 8'hFF, 8'h01, 1'b0, "R3 add wrap");
        run_op(0, 8'h7F, 8'h01, 1'b0, "R3 add overflow");
        run_op(1, 8'h22, 8'h66, 1'b1, "R3 adc 0x89");
        run_op(2, 8'h40, 8'h44, 1'b0, "R4 sub negative");
        run_op(3, 8'h40, 8'h3F, 1'b1, "R4 sbc zero");
        run_op(3, 8'h80, 8'h01, 1'b0, "R4 sbc overflow");
        run_op(4, 8'h44, 8'h44, 1'b0, "R5 cp equal");
        run_op(4, 8'h10, 8'h20, 1'b0, "R5 cp less");
        run_op(5, 8'hF0, 8'h3C, 1'b0, "R6 and");
        run_op(5, 8'h0F, 8'hF0, 1'b0, "R6 and zero");
        run_op(6, 8'h55, 8'h55, 1'b0, "R7 xor zero");
        run_op(7, 8'h80, 8'h01, 1'b0, "R7 or");
        run_op(0, 8'hF0, 8'h20, 1'b0, "R3 set carry");
        run_op(8, 8'h00, 8'h7F, 1'b0, "R8 inc 7F");
        run_op(8, 8'h00, 8'hFF, 1'b0, "R8 inc FF");
        run_op(9, 8'h00, 8'h80, 1'b0, "R8 dec 80");
        run_op(9, 8'h00, 8'h00, 1'b0, "R8 dec 00");
        run_op(10, 8'h5A, 8'h00, 1'b0, "R9 cpl");
        run_op(11, 8'h81, 8'h00, 1'b0, "R10 rlca 81");
        run_op(11, 8'h40, 8'h00, 1'b0, "R10 rlca 40");
        run_op(12, 8'h12, 8'h34, 1'b0, "R11 nibble rotate");
        run_op(12, 8'h03, 8'h00, 1'b0, "R11 nibble rotate zero");
        run_op(13, 8'hA5, 8'h3C, 1'b1, "R12 unused 13");
        run_op(15, 8'h00, 8'h11, 1'b0, "R12 unused 15");

        // R2: inputs move while strobe is low
        @(negedge clk);
        op = 4'd0; acc = 8'hFF; opnd = 8'hFF; carry_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 hold", last_r, last_m, mflags);
        if (sb.size() != 0) begin
            n_chk++; n_err++;
            $display("FAIL R2: got %0d pending items expected 0", sb.size());
        end
        finish_run();
    end
endmodule